// File: doc/BRIEF.md
# Linked-Descriptor Copy Engine

This block is a single-channel copy engine that takes its work from a chain of descriptors held in memory rather than from setup registers. Software places the address of the first descriptor in a head register and writes a start bit. From there the engine reads each four-word descriptor over its bus-master port and performs the byte copy that the descriptor describes. It then either stops or moves on to the descriptor named by the descriptor's link word. No processor action is needed between descriptors, so scattered buffers travel as one operation.

When a descriptor writes to the same destination as the one before it, the destination is held fixed. This lets a header and a payload from separate buffers arrive at a peripheral data port as one unbroken stream. Completion, errors and per-descriptor interrupts are reported in a status register and on a level interrupt line. The address of the descriptor in use and the bytes still left in its copy can be read at any time.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset the bus request and the interrupt are low, and the status register (word 2: bit 0 busy, bit 1 done, bit 2 error, bit 3 interrupt pending) reads zero.
- R2: A descriptor is fetched as four word reads (`m_size`=2) at its base address, then +4, +8 and +12, in that order. The words are source, destination, {flags[31:16], byte count[15:0]} and link.
- R3: For each byte of a descriptor, the engine performs one byte read (`m_size`=0) at the source, followed by one byte write of that data in `m_wdata[7:0]`. The source advances by one after each byte.
- R4: The destination advances by one per byte, except when the descriptor's destination field equals that of the previous descriptor in the chain. In that case every write goes to that same address.
- R5: After a copy the engine follows the link word with no register access. A descriptor with flags bit 0 (last) set ends the chain, clears busy and sets done.
- R6: A descriptor with flags bit 1 set raises interrupt pending, and the `irq` output, once its copy completes. It stays high until software writes 1 to status bit 3.
- R7: A head address whose two low bits are not zero sets error and makes no bus request. A non-last descriptor whose link is zero or not 4-byte aligned sets error after its copy and ends the chain.
- R8: Register word 3 returns the address of the current descriptor, and word 4 returns its remaining byte count. After completion these are the last descriptor's address and 0.
- R9: A start written while busy is ignored, and the running chain continues unchanged.
- R10: While a request waits for `m_ready`, its address, direction and size stay stable.
- R11: A descriptor with a byte count of zero makes no copy access, and the chain goes straight on to its link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word index (0 control, 1 head, 2 status, 3 current descriptor, 4 remaining) |
| reg_wdata | input | 32 | Register write data (control bit 0 = start; status bits 1..3 write-one-to-clear) |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| m_req | output | 1 | Bus-master request |
| m_we | output | 1 | 1 = write, 0 = read |
| m_addr | output | 32 | Byte address |
| m_size | output | 2 | 0 = byte, 2 = word |
| m_wdata | output | 32 | Write data, byte in bits 7:0 |
| m_ready | input | 1 | Completes the request in the cycle it is high together with `m_req` |
| m_rdata | input | 32 | Read data, valid in the completing cycle |
| irq | output | 1 | Level interrupt |

## Verification
Each bus access is due in the cycle after the previous handshake. The scoreboard therefore compares every access when it is presented, and it does so half a cycle before the edge at which `m_ready` completes it, while the bench's memory model throttles `m_ready` to stretch requests. Status bits settle one cycle after the last write handshake, because of a single decision cycle, and register reads are combinational. The bench therefore polls status on falling edges and compares the final register and memory contents only once busy has dropped. A misaligned start must produce no bus access at all, and the scoreboard counts any unexpected access as a failure.

// File: rtl/sg_dma_engine.sv
module sg_dma_engine #(
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [31:0]       m_addr,
  output logic [1:0]        m_size,
  output logic [31:0]       m_wdata,
  input  logic              m_ready,
  input  logic [31:0]       m_rdata,
  output logic              irq
);
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(0);
  localparam logic [REG_AW-1:0] A_HEAD = REG_AW'(1);
  localparam logic [REG_AW-1:0] A_STAT = REG_AW'(2);
  localparam logic [REG_AW-1:0] A_CUR  = REG_AW'(3);
  localparam logic [REG_AW-1:0] A_REM  = REG_AW'(4);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_FIN} st_t;

  st_t         state;
  logic [1:0]  widx;
  logic [31:0] head, desc_addr, src, dst, nxt, prev_dst;
  logic [15:0] cnt;
  logic [1:0]  flg;
  logic [7:0]  byte_q;
  logic        have_prev, dst_fixed, done_q, err_q, irq_q;

  logic busy, hs, start_hit;
  assign busy      = (state != S_IDLE);
  assign hs        = m_req && m_ready;
  assign start_hit = reg_we && (reg_addr == A_CTRL) && reg_wdata[0];

  assign m_req   = (state == S_FETCH) || (state == S_RD) || (state == S_WR);
  assign m_we    = (state == S_WR);
  assign m_size  = (state == S_FETCH) ? 2'd2 : 2'd0;
  assign m_wdata = {24'b0, byte_q};
  assign irq     = irq_q;

  always_comb begin
    case (state)
      S_FETCH: m_addr = desc_addr + {28'b0, widx, 2'b00};
      S_RD:    m_addr = src;
      default: m_addr = dst;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_HEAD:  reg_rdata = head;
      A_STAT:  reg_rdata = {28'b0, irq_q, err_q, done_q, busy};
      A_CUR:   reg_rdata = desc_addr;
      A_REM:   reg_rdata = {16'b0, cnt};
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;  widx <= '0;
      head <= '0; desc_addr <= '0; src <= '0; dst <= '0; nxt <= '0; prev_dst <= '0;
      cnt <= '0; flg <= '0; byte_q <= '0;
      have_prev <= 1'b0; dst_fixed <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_HEAD) head <= reg_wdata;
      if (reg_we && reg_addr == A_STAT) begin
        if (reg_wdata[1]) done_q <= 1'b0;
        if (reg_wdata[2]) err_q  <= 1'b0;
        if (reg_wdata[3]) irq_q  <= 1'b0;
      end
      case (state)
        S_IDLE: if (start_hit) begin
          done_q <= 1'b0;
          if (head[1:0] != 2'b00) err_q <= 1'b1;
          else begin
            err_q     <= 1'b0;
            desc_addr <= head;
            widx      <= '0;
            have_prev <= 1'b0;
            state     <= S_FETCH;
          end
        end
        S_FETCH: if (hs) begin
          widx <= widx + 2'd1;
          case (widx)
            2'd0: src <= m_rdata;
            2'd1: dst <= m_rdata;
            2'd2: begin cnt <= m_rdata[15:0]; flg <= m_rdata[17:16]; end
            default: begin
              nxt       <= m_rdata;
              dst_fixed <= have_prev && (dst == prev_dst);
              prev_dst  <= dst;
              have_prev <= 1'b1;
              state     <= (cnt != 16'd0) ? S_RD : S_FIN;
            end
          endcase
        end
        S_RD: if (hs) begin
          byte_q <= m_rdata[7:0];
          state  <= S_WR;
        end
        S_WR: if (hs) begin
          src <= src + 32'd1;
          if (!dst_fixed) dst <= dst + 32'd1;
          cnt   <= cnt - 16'd1;
          state <= (cnt == 16'd1) ? S_FIN : S_RD;
        end
        default: begin
          if (flg[1]) irq_q <= 1'b1;
          if (flg[0]) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else if (nxt == 32'd0 || nxt[1:0] != 2'b00) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else begin
            desc_addr <= nxt;
            widx      <= '0;
            state     <= S_FETCH;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sg_dma_engine_chk.sv
module sg_dma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic        m_req,
  input logic        m_we,
  input logic        m_ready,
  input logic [31:0] m_addr,
  input logic [1:0]  m_size,
  input logic        irq,
  input logic        busy,
  input logic        done_q
);
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_ready |=> m_req && $stable(m_addr) && $stable(m_we) && $stable(m_size)); // R10
  AST_WRITE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && m_we |-> m_size == 2'd0); // R3
  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_we && m_size == 2'd2 |-> m_addr[1:0] == 2'b00); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_req); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_we)); // R6
endmodule

bind sg_dma_engine sg_dma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .m_req(m_req), .m_we(m_we),
  .m_ready(m_ready), .m_addr(m_addr), .m_size(m_size), .irq(irq),
  .busy(busy), .done_q(done_q)
);

// File: tb/sg_dma_engine_bench.sv
module sg_dma_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic m_req, m_we, m_ready = 1'b0;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0] m_size;
  logic irq;

  always #5 clk = ~clk;

  sg_dma_engine u_sg_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata), .m_ready(m_ready),
    .m_rdata(m_rdata), .irq(irq));

  typedef struct packed { logic we; logic [31:0] addr; logic [1:0] size; logic [7:0] data; } txn_t;
  txn_t exp_q[$];
  logic [7:0] mem [0:8191];
  int total = 0, bad = 0, seen = 0;
  logic [31:0] prev_dst;
  logic have_prev;
  logic irq_busy;

  always_comb begin
    if (m_size == 2'd2)
      m_rdata = {mem[(m_addr + 3) & 32'h1FFF], mem[(m_addr + 2) & 32'h1FFF],
                 mem[(m_addr + 1) & 32'h1FFF], mem[m_addr & 32'h1FFF]};
    else
      m_rdata = {24'b0, mem[m_addr & 32'h1FFF]};
  end

  logic [2:0] rc = '0;
  always @(posedge clk) begin
    rc <= rc + 3'd1;
    m_ready <= (rc != 3'd2) && (rc != 3'd5);
  end

  always @(negedge clk) begin
    if (rst_n && m_req && m_ready) begin
      txn_t e;
      seen++;
      total++;
      if (m_we) mem[m_addr & 32'h1FFF] = m_wdata[7:0];
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R2/R3 unexpected access we=%0b addr=%h size=%0d expected none", m_we, m_addr, m_size);
      end else begin
        e = exp_q.pop_front();
        if (e.we != m_we || e.addr != m_addr || e.size != m_size || (m_we && e.data != m_wdata[7:0])) begin
          bad++;
          $display("FAIL R2/R3/R4 access actual we=%0b addr=%h size=%0d data=%h expected we=%0b addr=%h size=%0d data=%h",
                   m_we, m_addr, m_size, m_wdata[7:0], e.we, e.addr, e.size, e.data);
        end
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic put_word(logic [31:0] a, logic [31:0] w);
    for (int i = 0; i < 4; i++) mem[(a + i) & 32'h1FFF] = w[8*i +: 8];
  endtask

  task automatic put_desc(logic [31:0] a, logic [31:0] s, logic [31:0] d,
                          logic [15:0] n, logic [15:0] f, logic [31:0] nx);
    put_word(a, s); put_word(a + 4, d); put_word(a + 8, {f, n}); put_word(a + 12, nx);
  endtask

  task automatic expect_desc(logic [31:0] a, logic [31:0] s, logic [31:0] d, logic [15:0] n);
    logic fixed;
    for (int i = 0; i < 4; i++) exp_q.push_back('{1'b0, a + 32'(4 * i), 2'd2, 8'h00});
    fixed = have_prev && (d == prev_dst);
    prev_dst = d; have_prev = 1'b1;
    for (int i = 0; i < int'(n); i++) begin
      exp_q.push_back('{1'b0, s + 32'(i), 2'd0, 8'h00});
      exp_q.push_back('{1'b1, fixed ? d : d + 32'(i), 2'd0, mem[(s + 32'(i)) & 32'h1FFF]});
    end
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    int k = 0;
    irq_busy = 1'b0;
    do begin
      rd_reg(3'd2, st);
      if (st[0] && irq) irq_busy = 1'b1;
      k++;
    end while (st[0] && k < 5000);
    if (k >= 5000) begin
      total++; bad++;
      $display("FAIL watchdog chain did not finish actual=busy expected=idle");
    end
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 8192; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_reg(3'd2, v); check("R1 status", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 m_req", {31'b0, m_req}, 32'h0);

    // single descriptor, last + interrupt
    put_desc(32'h10, 32'h100, 32'h200, 16'd5, 16'h3, 32'h0);
    have_prev = 1'b0;
    expect_desc(32'h10, 32'h100, 32'h200, 16'd5);
    wr_reg(3'd1, 32'h10); wr_reg(3'd0, 32'h1);
    wait_idle();
    rd_reg(3'd2, v); check("R5 done status", v, 32'h0000_000A);
    check("R6 irq raised", {31'b0, irq}, 32'h1);
    for (int i = 0; i < 5; i++) check("R3 copied byte", {24'b0, mem[32'h200 + i]}, {24'b0, mem[32'h100 + i]});
    rd_reg(3'd3, v); check("R8 current descriptor", v, 32'h10);
    rd_reg(3'd4, v); check("R8 remaining", v, 32'h0);
    check("R2 all accesses seen", exp_q.size(), 0);
    wr_reg(3'd2, 32'h8);
    check("R6 irq cleared", {31'b0, irq}, 32'h0);

    // four-descriptor chain: shared destination, zero count, restart while busy
    put_desc(32'h40, 32'h500, 32'h300, 16'd3, 16'h0, 32'h60);
    put_desc(32'h60, 32'h520, 32'h300, 16'd4, 16'h2, 32'h80);
    put_desc(32'h80, 32'h540, 32'h300, 16'd0, 16'h0, 32'hA0);
    put_desc(32'hA0, 32'h560, 32'h700, 16'd2, 16'h1, 32'h0);
    have_prev = 1'b0;
    expect_desc(32'h40, 32'h500, 32'h300, 16'd3);
    expect_desc(32'h60, 32'h520, 32'h300, 16'd4);
    expect_desc(32'h80, 32'h540, 32'h300, 16'd0);
    expect_desc(32'hA0, 32'h560, 32'h700, 16'd2);
    wr_reg(3'd1, 32'h40); wr_reg(3'd0, 32'h1);
    wr_reg(3'd1, 32'h10); wr_reg(3'd0, 32'h1);   // R9: ignored
    wait_idle();
    check("R9 R11 chain accesses exact", exp_q.size(), 0);
    rd_reg(3'd2, v); check("R5 chain done", v, 32'h0000_000A);
    check("R6 irq mid-chain while busy", {31'b0, irq_busy}, 32'h1);
    check("R4 fixed destination last byte", {24'b0, mem[32'h300]}, {24'b0, mem[32'h523]});
    check("R4 increment after new dest", {24'b0, mem[32'h701]}, {24'b0, mem[32'h561]});
    rd_reg(3'd3, v); check("R8 last descriptor address", v, 32'hA0);
    wr_reg(3'd2, 32'hE);

    // misaligned head
    seen = 0;
    wr_reg(3'd1, 32'h42); wr_reg(3'd0, 32'h1);
    repeat (5) @(negedge clk);
    rd_reg(3'd2, v); check("R7 misaligned head error", v, 32'h4);
    check("R7 no bus access", seen, 0);

    // null link without last flag
    put_desc(32'hC0, 32'h580, 32'h780, 16'd2, 16'h0, 32'h0);
    have_prev = 1'b0;
    expect_desc(32'hC0, 32'h580, 32'h780, 16'd2);
    wr_reg(3'd1, 32'hC0); wr_reg(3'd0, 32'h1);
    wait_idle();
    rd_reg(3'd2, v); check("R7 null link error", v, 32'h4);
    check("R7 copy before error", {24'b0, mem[32'h781]}, {24'b0, mem[32'h581]});
    check("R7 accesses exact", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog global timeout actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule